// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Controller

The controller watches a set of external lines and turns qualifying transitions on them into interrupt requests and event pulses for two processor cores. Each line passes a two-flop synchroniser and an edge detector. Rising and falling detection are enabled per line. A detected edge, or a write to the software trigger register, forms the line's trigger. For each core, a trigger on a line whose interrupt mask bit is set latches a pending bit. The pending bit stays set until software clears it with a write-one-to-clear. While the pending bit and the mask bit are both set, that core's interrupt output for the line is high. The same trigger, gated by each core's event mask, appears as a single-cycle event pulse.

The low sixteen lines do not have a fixed pin. Each picks one of several 16-bit input ports through a 4-bit select field: line n takes bit n of the chosen port. Lines from 16 upward come straight from dedicated inputs. Only some lines can raise events, as fixed by a parameter. All configuration sits in a small word-addressed register file with a single write port and a combinational read port.

Top module: `line_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all interrupt and event outputs are low.
- R2: A line input is synchronised through two flops. After a change of the input, the event pulse is visible after the second rising clock edge and the pending bit after the third.
- R3: Word 0 holds the rising enables and word 1 the falling enables, with bit n for line n. Rising-only, falling-only and both (either edge) behave as set. With neither bit set, no edge triggers.
- R4: A trigger sets a core's pending bit only where that core's interrupt mask bit is 1. Core 0 uses mask word 3 and pending word 5. Core 1 uses mask word 6 and pending word 8. A core's interrupt output bit is high while its pending bit and mask bit are both 1. Clearing the mask lowers the output but keeps the pending bit.
- R5: Writing 1 to a bit of a pending word clears that bit. Writing 0 leaves it unchanged, and the other core's pending word is not affected.
- R6: When a trigger and a write-one-to-clear hit the same line in the same cycle, the pending bit stays set.
- R7: Writing 1 to bit n of word 2 (software trigger) acts as a trigger on line n, whatever the edge enables are. Word 2 always reads 0.
- R8: An event output bit pulses for one cycle on a trigger while that core's event mask bit is 1. The event masks are word 4 for core 0 and word 7 for core 1.
- R9: Event mask bits exist only for lines marked in the EVT_LINES parameter. A write of 1 to any other bit is ignored, and that bit reads 0.
- R10: Line n (n < 16) uses the 4-bit field at bit 4*(n mod 4) of word 12 + n/4. A value p below N_PORTS selects gpio_i[16*p + n]. Any other value feeds a constant 0.
- R11: Line 16 + k takes its input from ext_i[k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| gpio_i | input | 16*N_PORTS | Input ports, port p at bits 16p+15..16p |
| ext_i | input | N_LINES-16 | Dedicated inputs for lines 16 and up |
| irq0_o | output | N_LINES | Core 0 interrupt requests |
| irq1_o | output | N_LINES | Core 1 interrupt requests |
| evt0_o | output | N_LINES | Core 0 event pulses |
| evt1_o | output | N_LINES | Core 1 event pulses |

## Verification
A hardware edge can set a pending bit in the same cycle that software clears it. The bench forces this collision by counting the synchroniser delay from the input change and issuing the clear write so that it commits on the exact edge where the trigger is seen. The collision passes if the pending word still reads 1 afterwards and a later clear on its own empties it. The full sweep of lines against edge modes, and of select values against lines, is compared with expected values computed from the line index and the mode.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned MUX_LINES = 16;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned NCORE     = 2;

  typedef enum logic [3:0] {
    A_RISE = 4'd0,  A_FALL = 4'd1,  A_SWT  = 4'd2,
    A_IM0  = 4'd3,  A_EM0  = 4'd4,  A_PD0  = 4'd5,
    A_IM1  = 4'd6,  A_EM1  = 4'd7,  A_PD1  = 4'd8,
    A_SEL0 = 4'd12, A_SEL1 = 4'd13, A_SEL2 = 4'd14, A_SEL3 = 4'd15
  } reg_addr_e;
endpackage

// File: rtl/lic_edge.sv
module lic_edge #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      d_q  <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign rise_o = s2_q & ~d_q;
  assign fall_o = ~s2_q & d_q;

  // a rise seen now needs the raw input high two edges earlier
  assert_sync_depth_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & ~$past(async_i, 2)) == '0);
endmodule

// File: rtl/lic_portmux.sv
module lic_portmux
  import lic_pkg::*;
#(
  parameter int unsigned N_LINES = 20,
  parameter int unsigned N_PORTS = 4
) (
  input  logic [MUX_LINES*N_PORTS-1:0] gpio_i,
  input  logic [N_LINES-MUX_LINES-1:0] ext_i,
  input  logic [MUX_LINES*SEL_W-1:0]   sel_i,
  output logic [N_LINES-1:0]           line_o
);
  for (genvar n = 0; n < MUX_LINES; n++) begin : g_mux
    always_comb begin
      line_o[n] = 1'b0;
      for (int p = 0; p < N_PORTS; p++) begin
        if (sel_i[n*SEL_W +: SEL_W] == SEL_W'(p)) line_o[n] = gpio_i[p*MUX_LINES + n];
      end
    end
  end

  assign line_o[N_LINES-1:MUX_LINES] = ext_i;
endmodule

// File: rtl/lic_core_gate.sv
module lic_core_gate #(
  parameter int unsigned N_LINES = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] trig_i,
  input  logic [N_LINES-1:0] clr_i,
  input  logic [N_LINES-1:0] imask_i,
  input  logic [N_LINES-1:0] emask_i,
  output logic [N_LINES-1:0] pend_o,
  output logic [N_LINES-1:0] irq_o,
  output logic [N_LINES-1:0] evt_o
);
  logic [N_LINES-1:0] pend_q, set_w;

  assign set_w = trig_i & imask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_i) | set_w;  // set beats clear
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & imask_i;
  assign evt_o  = trig_i & emask_i;

  assert_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(clr_i & ~trig_i) |=> (pend_q & $past(clr_i & ~trig_i)) == '0);

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(trig_i & imask_i) |=> (pend_q & $past(trig_i & imask_i)) == $past(trig_i & imask_i));

  assert_unmasked_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~$past(pend_q) & ~$past(imask_i)) == '0);
endmodule

// File: rtl/line_irq_ctrl.sv
module line_irq_ctrl
  import lic_pkg::*;
#(
  parameter int unsigned N_LINES   = 20,
  parameter int unsigned N_PORTS   = 4,
  parameter logic [31:0] EVT_LINES = 32'h0000_FFFF
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [3:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic [MUX_LINES*N_PORTS-1:0] gpio_i,
  input  logic [N_LINES-MUX_LINES-1:0] ext_i,
  output logic [N_LINES-1:0]           irq0_o,
  output logic [N_LINES-1:0]           irq1_o,
  output logic [N_LINES-1:0]           evt0_o,
  output logic [N_LINES-1:0]           evt1_o
);
  localparam logic [N_LINES-1:0] EVT_MASK = EVT_LINES[N_LINES-1:0];

  logic [N_LINES-1:0] rise_en_q, fall_en_q;
  logic [N_LINES-1:0] im_q [NCORE];
  logic [N_LINES-1:0] em_q [NCORE];
  logic [MUX_LINES-1:0][SEL_W-1:0] sel_q;
  logic [MUX_LINES*SEL_W-1:0] sel_flat;
  logic [N_LINES-1:0] wl, line_w, rise_w, fall_w, sw_w, trig_w;
  logic [N_LINES-1:0] clr_w [NCORE];
  logic [N_LINES-1:0] pend_w [NCORE];
  logic [N_LINES-1:0] irq_w [NCORE];
  logic [N_LINES-1:0] evt_w [NCORE];

  assign wl = wdata_i[N_LINES-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      im_q      <= '{default: '0};
      em_q      <= '{default: '0};
      sel_q     <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_RISE: rise_en_q <= wl;
        A_FALL: fall_en_q <= wl;
        A_IM0:  im_q[0]   <= wl;
        A_IM1:  im_q[1]   <= wl;
        A_EM0:  em_q[0]   <= wl & EVT_MASK;
        A_EM1:  em_q[1]   <= wl & EVT_MASK;
        A_SEL0, A_SEL1, A_SEL2, A_SEL3:
          for (int j = 0; j < 4; j++) sel_q[{addr_i[1:0], 2'(j)}] <= wdata_i[4*j +: 4];
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < MUX_LINES; n++) begin : g_flat
    assign sel_flat[n*SEL_W +: SEL_W] = sel_q[n];
  end

  lic_portmux #(.N_LINES(N_LINES), .N_PORTS(N_PORTS)) u_mux (
    .gpio_i(gpio_i), .ext_i(ext_i), .sel_i(sel_flat), .line_o(line_w)
  );

  lic_edge #(.W(N_LINES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(line_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  assign sw_w     = (we_i && addr_i == A_SWT) ? wl : '0;
  assign clr_w[0] = (we_i && addr_i == A_PD0) ? wl : '0;
  assign clr_w[1] = (we_i && addr_i == A_PD1) ? wl : '0;
  assign trig_w   = (rise_w & rise_en_q) | (fall_w & fall_en_q) | sw_w;

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    lic_core_gate #(.N_LINES(N_LINES)) u_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_w), .clr_i(clr_w[c]),
      .imask_i(im_q[c]), .emask_i(em_q[c]),
      .pend_o(pend_w[c]), .irq_o(irq_w[c]), .evt_o(evt_w[c])
    );
  end

  assign irq0_o = irq_w[0];
  assign irq1_o = irq_w[1];
  assign evt0_o = evt_w[0];
  assign evt1_o = evt_w[1];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_RISE: rdata_o[N_LINES-1:0] = rise_en_q;
      A_FALL: rdata_o[N_LINES-1:0] = fall_en_q;
      A_IM0:  rdata_o[N_LINES-1:0] = im_q[0];
      A_IM1:  rdata_o[N_LINES-1:0] = im_q[1];
      A_EM0:  rdata_o[N_LINES-1:0] = em_q[0];
      A_EM1:  rdata_o[N_LINES-1:0] = em_q[1];
      A_PD0:  rdata_o[N_LINES-1:0] = pend_w[0];
      A_PD1:  rdata_o[N_LINES-1:0] = pend_w[1];
      A_SEL0, A_SEL1, A_SEL2, A_SEL3:
        for (int j = 0; j < 4; j++) rdata_o[4*j +: 4] = sel_q[{addr_i[1:0], 2'(j)}];
      default: ;
    endcase
  end

  assert_evt_capable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt0_o | evt1_o) & ~EVT_MASK) == '0);

  assert_swtrig_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_SWT) |=> (pend_w[0] & $past(wl & im_q[0])) == $past(wl & im_q[0]));
endmodule

// File: tb/sim_line_irq_ctrl.sv
module sim_line_irq_ctrl;
  import lic_pkg::*;
  localparam int CLK_P = 10;
  localparam int NL = 20;
  localparam int NP = 4;
  localparam logic [31:0] CAP = 32'h0000_FFFF;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [16*NP-1:0] gpio = '0;
  logic [NL-17:0] ext = '0;
  logic [NL-1:0] irq0, irq1, evt0, evt1;
  int n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  line_irq_ctrl #(.N_LINES(NL), .N_PORTS(NP), .EVT_LINES(CAP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .gpio_i(gpio), .ext_i(ext),
    .irq0_o(irq0), .irq1_o(irq1), .evt0_o(evt0), .evt1_o(evt1)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rdchk(string req, logic [3:0] a, logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic set_line(int n, logic v);
    if (n < 16) gpio[n] = v; else ext[n-16] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 16; a++) rdchk("R1 reset reg", 4'(a), 32'h0);
    chk("R1 reset outputs", 32'({irq0 | irq1 | evt0 | evt1}), 32'h0);

    // R2 R3 R8 R9 R11: every line against every edge mode, core 0
    for (int ln = 0; ln < NL; ln++) begin
      for (int md = 0; md < 4; md++) begin
        logic [31:0] bit_l, ev_exp;
        bit_l = 32'h1 << ln;
        ev_exp = CAP[ln] ? bit_l : 32'h0;
        wr(A_RISE, md[0] ? bit_l : 0);
        wr(A_FALL, md[1] ? bit_l : 0);
        wr(A_IM0, bit_l);
        wr(A_EM0, bit_l);
        rdchk("R9 event mask readback", A_EM0, ev_exp);
        wr(A_PD0, 32'hFFFFFFFF);
        set_line(ln, 1'b1);
        repeat (2) @(negedge clk);
        chk("R8 R2 rise event pulse", 32'(evt0), md[0] ? ev_exp : 0);
        @(negedge clk);
        chk("R8 event one cycle", 32'(evt0), 0);
        rdchk("R3 R11 rise pending", A_PD0, md[0] ? bit_l : 0);
        chk("R4 irq follows pending", 32'(irq0), md[0] ? bit_l : 0);
        wr(A_PD0, 32'hFFFFFFFF);
        set_line(ln, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 fall event pulse", 32'(evt0), md[1] ? ev_exp : 0);
        @(negedge clk);
        rdchk("R3 fall pending", A_PD0, md[1] ? bit_l : 0);
        wr(A_PD0, 32'hFFFFFFFF);
      end
    end

    // R10 port selection sweep
    wr(A_RISE, 32'hFFFFF); wr(A_FALL, 0); wr(A_IM0, 32'hFFFFF); wr(A_EM0, 0);
    for (int n = 0; n < 16; n++) begin
      for (int p = 0; p <= NP; p++) begin
        logic [31:0] fld;
        fld = 32'(p) << (4*(n%4));
        wr(4'(12 + n/4), fld);
        rdchk("R10 select readback", 4'(12 + n/4), fld);
        wr(A_PD0, 32'hFFFFFFFF);
        for (int q = 0; q < NP; q++) if (q != p) gpio[q*16+n] = 1'b1;
        repeat (3) @(negedge clk);
        rdchk("R10 unselected ports ignored", A_PD0, 0);
        if (p < NP) begin
          gpio[p*16+n] = 1'b1;
          repeat (3) @(negedge clk);
          rdchk("R10 selected port triggers", A_PD0, 32'h1 << n);
        end
        gpio = '0;
        repeat (3) @(negedge clk);
        wr(4'(12 + n/4), 0);
      end
    end

    // R4 core separation and masking
    wr(A_PD0, 32'hFFFFFFFF);
    wr(A_IM0, 0); wr(A_IM1, 32'h8); wr(A_EM1, 32'h8); wr(A_RISE, 32'h8);
    set_line(3, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 core1 event", 32'(evt1), 32'h8);
    chk("R8 core0 no event", 32'(evt0), 0);
    @(negedge clk);
    rdchk("R4 core1 pending", A_PD1, 32'h8);
    rdchk("R4 core0 masked not pending", A_PD0, 0);
    chk("R4 core1 irq", 32'(irq1), 32'h8);
    chk("R4 core0 irq", 32'(irq0), 0);
    wr(A_IM1, 0);
    chk("R4 mask off lowers irq", 32'(irq1), 0);
    rdchk("R4 pending kept", A_PD1, 32'h8);
    set_line(3, 1'b0);
    wr(A_PD1, 32'hFFFFFFFF);

    // R7 software trigger, R5 write-one-to-clear
    wr(A_RISE, 0); wr(A_FALL, 0);
    wr(A_IM0, 32'h20000); wr(A_IM1, 32'h20000);
    wr(A_SWT, 32'h20020);
    rdchk("R7 sw pending core0", A_PD0, 32'h20000);
    rdchk("R7 sw pending core1", A_PD1, 32'h20000);
    rdchk("R7 sw reads zero", A_SWT, 0);
    wr(A_PD0, 0);
    rdchk("R5 zero write no effect", A_PD0, 32'h20000);
    wr(A_PD0, 32'h20000);
    rdchk("R5 one clears", A_PD0, 0);
    rdchk("R5 other core untouched", A_PD1, 32'h20000);
    wr(A_PD1, 32'hFFFFFFFF);

    // R6 edge and clear in the same cycle
    wr(A_IM0, 32'h4); wr(A_RISE, 32'h4);
    wr(A_SWT, 32'h4);
    set_line(2, 1'b1);
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = A_PD0; wdata = 32'h4;
    @(negedge clk); we = 1'b0;
    rdchk("R6 edge beats clear", A_PD0, 32'h4);
    wr(A_PD0, 32'h4);
    rdchk("R6 lone clear", A_PD0, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule